// File: doc/BRIEF.md
# Two-Cycle Instruction Sequencer Core

This block is the control unit and datapath of a small 32-bit load/store processor. It holds the program counter, a sixteen-entry register file and a status register that carries four arithmetic flags. It runs every instruction in exactly two clock cycles. In the fetch cycle it reads the word at the program counter from a synchronous memory. In the execute cycle it decodes that word and performs one operation: a register add, a register subtract, an add with a sign-extended 8-bit constant, a compare, a load, a store, or a branch relative to the program counter.

The memory port is word addressed and returns read data one cycle after the address is presented. That one-cycle gap is what makes the instruction available in the execute cycle. A load issues its address in the execute cycle, and the returned word is written into the register file during the fetch cycle of the next instruction, so it is ready to be read when that instruction executes. The port has a fixed latency and cannot stall, so it uses plain control pins and has no valid/ready handshake.

Instruction layout: opcode in bits 31:28, destination register in 27:24, first source in 23:20, second source in 19:16, and the 8-bit constant in 7:0. A branch carries its condition in bits 27:24 and a 24-bit two's-complement offset in bits 23:0.

Top module: `seq2_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the PC is 0x8000 and the status register is zero. The first fetch reads address 0x8000.
- R2: Fetch and execute cycles alternate strictly. During fetch, mem_rd is 1, mem_wr is 0 and mem_addr equals the PC. Each instruction therefore takes two cycles.
- R3: Opcode 1 (add) writes Rn + Rm into Rd, updates the flags and advances the PC by 1.
- R4: Opcode 2 (subtract) writes Rn + ~Rm + 1 into Rd. Opcode 4 (compare) computes the same sum but only updates the flags and leaves the register named in bits 27:24 unchanged. Both advance the PC by 1.
- R5: The flags occupy status bits 31 (N, result MSB), 30 (Z, result zero), 29 (C, adder carry-out) and 28 (V, signed overflow). All other status bits read as 0.
- R6: Opcode 3 writes Rn plus the sign-extended bits 7:0 into Rd, updates the flags and advances the PC by 1.
- R7: Opcode 5 (load) writes the memory word at address Rn into Rd. The very next instruction sees the loaded value. The PC advances by 1.
- R8: Opcode 6 (store) drives mem_wr for one execute cycle, with mem_addr = Rn and mem_wdata = Rd. No other cycle writes memory. The PC advances by 1.
- R9: Opcode 7 (branch) with condition 0 always loads PC + sign-extended offset. This covers forward, backward and zero offsets.
- R10: Branch conditions are 1 EQ (Z=1), 2 NE (Z=0), 3 LT (N≠V) and 4 GE (N=V). Condition codes 5 to 15 are never taken. A branch that is not taken advances the PC by 1.
- R11: Opcodes 0 and 8 to 15 change no register and no flag, and advance the PC by 1.
- R12: Loads, stores, branches and undefined opcodes leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Word address: PC in fetch, Rn in execute |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe (store only) |
| mem_wdata | output | 32 | Store data (Rd) |
| mem_rdata | input | 32 | Read data, one cycle after the address |
| pc_o | output | 32 | Current program counter |
| psr_o | output | 32 | Status register, flags in bits 31:28 |

## Verification
The adder is driven with operand pairs chosen so that each flag is set on its own:
- a positive-plus-negative add that produces only a carry;
- a maximum-positive-plus-one add that produces N and V without a carry;
- a small-minus-larger subtract that yields N without a carry;
- a self-compare that yields Z with a carry.

Each pair separates a wrong flag formula or a swapped operand order. Branch programs run every condition code both taken and not taken, including an undefined code and a backward loop, so a wrong condition or sign extension changes the stored result. A load followed at once by a use of the loaded register separates a late load write-back from a correct one. A compare with a nonzero destination field and undefined opcodes shaped like real instructions show whether anything is written that should not be.

// File: rtl/seq2_pkg.sv
package seq2_pkg;
  localparam logic [3:0] OP_ADD  = 4'h1;
  localparam logic [3:0] OP_SUB  = 4'h2;
  localparam logic [3:0] OP_ADDI = 4'h3;
  localparam logic [3:0] OP_CMP  = 4'h4;
  localparam logic [3:0] OP_LD   = 4'h5;
  localparam logic [3:0] OP_ST   = 4'h6;
  localparam logic [3:0] OP_BR   = 4'h7;

  localparam logic [3:0] CC_AL = 4'h0;
  localparam logic [3:0] CC_EQ = 4'h1;
  localparam logic [3:0] CC_NE = 4'h2;
  localparam logic [3:0] CC_LT = 4'h3;
  localparam logic [3:0] CC_GE = 4'h4;

  typedef enum logic {PH_FETCH = 1'b0, PH_EXEC = 1'b1} phase_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/seq2_alu.sv
module seq2_alu
  import seq2_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output flags_t       fl
);
  logic [W:0]   sum;
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    y     = sum[W-1:0];
    fl.n  = y[W-1];
    fl.z  = (y == '0);
    fl.c  = sum[W];
    fl.v  = (a[W-1] == b_eff[W-1]) && (y[W-1] != a[W-1]);
  end
endmodule

// File: rtl/seq2_brcond.sv
module seq2_brcond
  import seq2_pkg::*;
(
  input  logic [3:0] cond,
  input  flags_t     fl,
  output logic       take
);
  always_comb begin
    unique case (cond)
      CC_AL:   take = 1'b1;
      CC_EQ:   take = fl.z;
      CC_NE:   take = !fl.z;
      CC_LT:   take = (fl.n != fl.v);
      CC_GE:   take = (fl.n == fl.v);
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/seq2_regfile.sv
module seq2_regfile #(
  parameter int W   = 32,
  parameter int N   = 16,
  parameter int NRD = 3,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra [NRD],
  output logic [W-1:0]  rdat [NRD],
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdat[p] = regs[ra[p]];
  end
endmodule

// File: rtl/seq2_core.sv
module seq2_core
  import seq2_pkg::*;
#(
  parameter int              DW       = 32,
  parameter int              NREG     = 16,
  parameter logic [DW-1:0]   RESET_PC = 32'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] psr_o
);
  localparam int RW   = $clog2(NREG);
  localparam int NRD  = 3;
  localparam int OFFW = 24;
  localparam int IMMW = 8;

  phase_e        ph_q;
  logic          in_exec;
  logic [DW-1:0] pc_q, pc_nxt;
  flags_t        nzcv_q, alu_fl;
  logic          ld_pend_q;
  logic [RW-1:0] ld_rd_q;

  // Instruction fields, valid during the execute cycle
  logic [3:0]    op;
  logic [RW-1:0] rd_i, rn_i, rm_i;
  logic [DW-1:0] imm_x, off_x;
  assign op    = mem_rdata[31:28];
  assign rd_i  = mem_rdata[24 +: RW];
  assign rn_i  = mem_rdata[20 +: RW];
  assign rm_i  = mem_rdata[16 +: RW];
  assign imm_x = {{(DW-IMMW){mem_rdata[IMMW-1]}}, mem_rdata[IMMW-1:0]};
  assign off_x = {{(DW-OFFW){mem_rdata[OFFW-1]}}, mem_rdata[OFFW-1:0]};

  assign in_exec = (ph_q == PH_EXEC);

  logic is_add, is_sub, is_addi, is_cmp, is_ld, is_st, is_br, is_alu, wr_alu;
  always_comb begin
    is_add  = in_exec && (op == OP_ADD);
    is_sub  = in_exec && (op == OP_SUB);
    is_addi = in_exec && (op == OP_ADDI);
    is_cmp  = in_exec && (op == OP_CMP);
    is_ld   = in_exec && (op == OP_LD);
    is_st   = in_exec && (op == OP_ST);
    is_br   = in_exec && (op == OP_BR);
    is_alu  = is_add || is_sub || is_addi || is_cmp;
    wr_alu  = is_add || is_sub || is_addi;
  end

  // Register file: ports 0/1/2 read Rn/Rm/Rd
  logic [RW-1:0] ra [NRD];
  logic [DW-1:0] rv [NRD];
  logic          rf_we;
  logic [RW-1:0] rf_wa;
  logic [DW-1:0] rf_wd, alu_y;

  assign ra[0] = rn_i;
  assign ra[1] = rm_i;
  assign ra[2] = rd_i;

  always_comb begin
    if (!in_exec) begin
      rf_we = ld_pend_q;
      rf_wa = ld_rd_q;
      rf_wd = mem_rdata;
    end else begin
      rf_we = wr_alu;
      rf_wa = rd_i;
      rf_wd = alu_y;
    end
  end

  seq2_regfile #(.W(DW), .N(NREG), .NRD(NRD)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .ra   (ra),
    .rdat (rv),
    .we   (rf_we),
    .wa   (rf_wa),
    .wd   (rf_wd)
  );

  seq2_alu #(.W(DW)) u_alu (
    .a  (rv[0]),
    .b  (is_addi ? imm_x : rv[1]),
    .sub(is_sub || is_cmp),
    .y  (alu_y),
    .fl (alu_fl)
  );

  logic br_take;
  seq2_brcond u_cond (
    .cond(mem_rdata[27:24]),
    .fl  (nzcv_q),
    .take(br_take)
  );

  assign pc_nxt = (is_br && br_take) ? pc_q + off_x : pc_q + DW'(1);

  // Memory port
  assign mem_addr  = in_exec ? rv[0] : pc_q;
  assign mem_rd    = !in_exec || is_ld;
  assign mem_wr    = is_st;
  assign mem_wdata = rv[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_FETCH;
      pc_q      <= RESET_PC;
      nzcv_q    <= '0;
      ld_pend_q <= 1'b0;
      ld_rd_q   <= '0;
    end else if (in_exec) begin
      ph_q      <= PH_FETCH;
      pc_q      <= pc_nxt;
      if (is_alu) nzcv_q <= alu_fl;
      ld_pend_q <= is_ld;
      ld_rd_q   <= rd_i;
    end else begin
      ph_q      <= PH_EXEC;
      ld_pend_q <= 1'b0;
    end
  end

  assign pc_o  = pc_q;
  assign psr_o = {nzcv_q, {(DW-4){1'b0}}};
endmodule

// File: rtl/seq2_core_chk.sv
module seq2_core_chk
  import seq2_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] RESET_PC = 32'h8000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_exec,
  input logic [DW-1:0] pc,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_addr,
  input logic [3:0]    op,
  input logic [DW-1:0] psr
);
  logic op_keeps_flags;
  assign op_keeps_flags = !(op == OP_ADD || op == OP_SUB || op == OP_ADDI || op == OP_CMP);

  a_r1_start_pc: assert property (@(posedge clk) $rose(rst_n) |-> (pc == RESET_PC && !in_exec));

  a_r2_exec_to_fetch: assert property (@(posedge clk) disable iff (!rst_n) in_exec |=> !in_exec);

  a_r2_fetch_to_exec: assert property (@(posedge clk) disable iff (!rst_n) !in_exec |=> in_exec);

  a_r2_fetch_port: assert property (@(posedge clk) disable iff (!rst_n)
    !in_exec |-> (mem_rd && !mem_wr && mem_addr == pc));

  a_r3_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && op != OP_BR) |=> (pc == $past(pc) + DW'(1)));

  a_r8_store_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (in_exec && op == OP_ST));

  a_r12_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_exec || op_keeps_flags) |=> $stable(psr));

  a_r5_low_bits: assert property (@(posedge clk) disable iff (!rst_n) psr[DW-5:0] == '0);
endmodule

bind seq2_core seq2_core_chk #(.DW(DW), .RESET_PC(RESET_PC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_exec (in_exec),
  .pc      (pc_q),
  .mem_rd  (mem_rd),
  .mem_wr  (mem_wr),
  .mem_addr(mem_addr),
  .op      (op),
  .psr     (psr_o)
);

// File: tb/seq2_core_bench.sv
module seq2_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, pc_o, psr_o;
  logic        mem_rd, mem_wr;

  logic [31:0] mem [128];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  seq2_core u_seq2_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc_o(pc_o), .psr_o(psr_o)
  );

  // Behavioural memory: index = address bits 6:0 (program at 0x8000.., data at 0x40..)
  initial mem_rdata = '0;
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[6:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[6:0]];
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired: act=%0d cycles exp<=20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_r(logic [3:0] op, logic [3:0] rd, logic [3:0] rn, logic [3:0] rm);
    return {op, rd, rn, rm, 16'h0};
  endfunction
  function automatic logic [31:0] f_i(logic [3:0] rd, logic [3:0] rn, logic [7:0] imm);
    return {4'h3, rd, rn, 12'h0, imm};
  endfunction
  function automatic logic [31:0] f_b(logic [3:0] cc, logic [23:0] off);
    return {4'h7, cc, off};
  endfunction

  task automatic hold_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 128; i++) mem[i] = '0;
  endtask

  task automatic go(int n);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    hold_reset();
    mem[0] = f_i(4'd1, 4'd0, 8'd1);
    mem[1] = f_b(4'h0, 24'h0);
    chk("R1 pc in reset", pc_o, 32'h8000);
    chk("R1 psr in reset", psr_o, 32'h0);
    chk("R2 fetch addr in reset", mem_addr, 32'h8000);
    chk("R2 fetch strobes", {30'h0, mem_rd, mem_wr}, 32'h2);
    go(1);
    chk("R1 pc held through first fetch", pc_o, 32'h8000);
    go(1);
    chk("R2 pc after two cycles", pc_o, 32'h8001);
    chk("R2 second fetch addr", mem_addr, 32'h8001);
    go(4);
    chk("R9 zero-offset branch holds pc", pc_o, 32'h8001);
  endtask

  task automatic t_add_carry();
    hold_reset();
    mem[0] = f_i(4'd4, 4'd0, 8'h40);
    mem[1] = f_i(4'd5, 4'd0, 8'h41);
    mem[2] = f_i(4'd1, 4'd0, 8'd5);
    mem[3] = f_i(4'd2, 4'd0, 8'hFD);
    mem[4] = f_r(4'h1, 4'd3, 4'd1, 4'd2);
    mem[5] = f_r(4'h6, 4'd3, 4'd4, 4'd0);
    mem[6] = f_r(4'h6, 4'd2, 4'd5, 4'd0);
    mem[7] = f_b(4'h0, 24'h0);
    go(30);
    chk("R3 add 5+(-3)", mem[64], 32'd2);
    chk("R6 imm sign extension", mem[65], 32'hFFFF_FFFD);
    chk("R5 carry only (R12 stores keep flags)", psr_o, 32'h2000_0000);
    chk("R8 pc at halt", pc_o, 32'h8007);
  endtask

  task automatic t_overflow_load();
    hold_reset();
    mem[66] = 32'h7FFF_FFFF;
    mem[67] = 32'h1;
    mem[0] = f_i(4'd4, 4'd0, 8'h42);
    mem[1] = f_i(4'd5, 4'd0, 8'h43);
    mem[2] = f_i(4'd6, 4'd0, 8'h44);
    mem[3] = f_r(4'h5, 4'd1, 4'd4, 4'd0);
    mem[4] = f_r(4'h5, 4'd2, 4'd5, 4'd0);
    mem[5] = f_r(4'h1, 4'd3, 4'd1, 4'd2);
    mem[6] = f_r(4'h6, 4'd3, 4'd6, 4'd0);
    mem[7] = f_b(4'h0, 24'h0);
    go(30);
    chk("R7 load then immediate use", mem[68], 32'h8000_0000);
    chk("R5 N and V on overflow", psr_o, 32'h9000_0000);
  endtask

  task automatic t_sub_cmp();
    hold_reset();
    mem[0] = f_i(4'd1, 4'd0, 8'd3);
    mem[1] = f_i(4'd2, 4'd0, 8'd5);
    mem[2] = f_i(4'd4, 4'd0, 8'h40);
    mem[3] = f_i(4'd6, 4'd0, 8'h41);
    mem[4] = f_i(4'd3, 4'd0, 8'd7);
    mem[5] = f_r(4'h2, 4'd5, 4'd1, 4'd2);
    mem[6] = f_r(4'h6, 4'd5, 4'd6, 4'd0);
    mem[7] = f_r(4'h4, 4'd3, 4'd1, 4'd1);
    mem[8] = f_r(4'h6, 4'd3, 4'd4, 4'd0);
    mem[9] = f_b(4'h0, 24'h0);
    go(13);
    chk("R4 sub 3-5 flags N only", psr_o, 32'h8000_0000);
    go(20);
    chk("R4 sub 3-5 result", mem[65], 32'hFFFF_FFFE);
    chk("R4 compare leaves Rd", mem[64], 32'd7);
    chk("R5 self compare Z and C", psr_o, 32'h6000_0000);
  endtask

  task automatic t_branch_cond();
    hold_reset();
    mem[0]  = f_i(4'd1, 4'd0, 8'd4);
    mem[1]  = f_i(4'd2, 4'd0, 8'd4);
    mem[2]  = f_i(4'd4, 4'd0, 8'h40);
    mem[3]  = f_i(4'd5, 4'd0, 8'd1);
    mem[4]  = f_r(4'h4, 4'd0, 4'd1, 4'd2);
    mem[5]  = f_b(4'h2, 24'd2);
    mem[6]  = f_b(4'h1, 24'd2);
    mem[7]  = f_i(4'd5, 4'd0, 8'd9);
    mem[8]  = f_r(4'h6, 4'd5, 4'd4, 4'd0);
    mem[9]  = f_b(4'hF, 24'd5);
    mem[10] = f_b(4'h4, 24'd2);
    mem[11] = f_i(4'd5, 4'd0, 8'd9);
    mem[12] = f_i(4'd6, 4'd0, 8'h41);
    mem[13] = f_r(4'h6, 4'd5, 4'd6, 4'd0);
    mem[14] = f_b(4'h0, 24'h0);
    go(50);
    chk("R10 NE not taken, EQ taken", mem[64], 32'd1);
    chk("R10 code 15 not taken, GE taken", mem[65], 32'd1);
    chk("R10 final pc", pc_o, 32'h800E);
  endtask

  task automatic t_loop_lt();
    hold_reset();
    mem[0]  = f_i(4'd1, 4'd0, 8'd3);
    mem[1]  = f_i(4'd2, 4'd0, 8'd0);
    mem[2]  = f_i(4'd4, 4'd0, 8'h40);
    mem[3]  = f_i(4'd2, 4'd2, 8'd1);
    mem[4]  = f_i(4'd1, 4'd1, 8'hFF);
    mem[5]  = f_r(4'h4, 4'd0, 4'd1, 4'd0);
    mem[6]  = f_b(4'h2, 24'hFFFFFD);
    mem[7]  = f_r(4'h6, 4'd2, 4'd4, 4'd0);
    mem[8]  = f_r(4'h4, 4'd0, 4'd1, 4'd4);
    mem[9]  = f_b(4'h3, 24'd2);
    mem[10] = f_r(4'h6, 4'd1, 4'd4, 4'd0);
    mem[11] = f_b(4'h0, 24'h0);
    go(80);
    chk("R9 backward loop count and R10 LT taken", mem[64], 32'd3);
    chk("R5 0-64 sets N only", psr_o, 32'h8000_0000);
    chk("R10 LT lands on halt", pc_o, 32'h800B);
  endtask

  task automatic t_undefined();
    hold_reset();
    mem[0] = f_i(4'd1, 4'd0, 8'd5);
    mem[1] = f_i(4'd4, 4'd0, 8'h40);
    mem[2] = f_r(4'h4, 4'd0, 4'd1, 4'd1);
    mem[3] = 32'hF150_0000;
    mem[4] = 32'h0140_0000;
    mem[5] = f_r(4'h6, 4'd1, 4'd4, 4'd0);
    mem[6] = f_b(4'h0, 24'h0);
    go(8);
    chk("R11 undefined opcode advances pc", pc_o, 32'h8004);
    go(30);
    chk("R11 undefined opcodes leave register", mem[64], 32'd5);
    chk("R12 undefined opcodes keep flags", psr_o, 32'h6000_0000);
    chk("R11 final pc", pc_o, 32'h8006);
  endtask

  initial begin
    t_reset();
    t_add_carry();
    t_overflow_load();
    t_sub_cmp();
    t_branch_cond();
    t_loop_lt();
    t_undefined();
    summary();
    $finish;
  end
endmodule